// File: doc/BRIEF.md
# Parallel-Port Drive Attach Sequencer

This block owns the data and control lines of a host parallel port and steps a drive-side bridge chip into or out of its attached state. A single `go` pulse, qualified by `op`, starts either an attach or a detach sequence. Each sequence is built from a fixed handshake: a run of marker bytes on the data lines, three status checkpoints, then the selector byte and a short strobe on the control lines. The selector byte decides what the bridge does with the handshake: init, attach or detach.

Attach plays the handshake twice, first with the init selector and then with the attach selector. It then toggles the control lines and loads four bridge configuration registers. Detach plays the handshake once with the detach selector and finishes with a control value that also turns off the activity LED. Every port write stays on the pins for a programmable number of cycles. The three status checkpoints are kept for diagnostics and compared with their expected values. A difference raises a flag but does not stop the sequence.

A second adapter wiring is supported through `alt_mode`. In that mode the control byte is inverted on selected lines, and the status lines are reordered into the standard layout before they are sampled.

Top module: `pp_attach_seq`

## Requirements
- R1: After synchronous reset, busy, done and mismatch are 0, the data lines and all three sample registers read 0x00, and the logical control value is 0x00 (pins show 0x00, or 0x8B with alt_mode).
- R2: One handshake, in order: control 0x04; data 0x22, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78; the selector byte on data; control 0x04, 0x05, 0x04; data 0xFF.
- R3: Attach (op=0) plays the handshake with selector 0x00, then with 0xE0. It then writes data 0x00, control 0x01, control 0x04. Next come four register writes, each made of data 0x60+address, control 0x01, data value, control 0x04, with (address,value) pairs in the order (0x08,0x10), (0x0C,0x14), (0x0A,0x38), (0x12,0x10). It ends with logical control 0x04.
- R4: Detach (op=1) plays the handshake with selector 0x30, then writes control 0x8C as its last step.
- R5: samp1 takes the status byte ANDed with 0xB8 during the 0xFF marker that follows 0x00. samp2 takes it ANDed with 0xB8 during 0x87, and samp3 takes it ANDed with 0x38 during 0x78. Each is captured on the edge that closes that write's window. In an attach, the second handshake's values remain. Outside a sequence the samples do not change.
- R6: The status byte is built from the five status lines. In standard mode, line i goes to byte bit i+3. With alt_mode, line0 goes to bit6, the inverse of line1 to bit7, line2 to bit5, line3 to bit4 and line4 to bit3. Bits 2..0 are zero.
- R7: With alt_mode=1, pp_ctrl is the logical control value XOR 0x8B at all times.
- R8: Each write stays on the port for max(hold_cycles,1)+1 cycles. busy stays high for 45×(max(hold_cycles,1)+1) cycles in an attach and 14×(max(hold_cycles,1)+1) cycles in a detach.
- R9: done is a single-cycle pulse, raised in the cycle busy falls and at no other time.
- R10: At completion, mismatch is set if samp1≠0xB8, samp2≠0x18, or samp3≠0x30 (attach) / 0x38 (detach). Otherwise it is cleared. It is also cleared when a new sequence starts. A mismatch never shortens the sequence.
- R11: go is ignored while busy, including the final cycle of a sequence. In that case the data, op, and length of the running sequence are unchanged.
- R12: Reset asserted in the middle of a sequence returns every output to the R1 state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, taken when idle |
| op | input | 1 | 0 = attach, 1 = detach; sampled with go |
| alt_mode | input | 1 | Alternate adapter wiring |
| hold_cycles | input | HOLD_W | Write window length control (0 acts as 1) |
| pp_status | input | 5 | Raw status lines from the port |
| pp_data | output | 8 | Port data lines |
| pp_ctrl | output | 8 | Port control lines, bit 7 drives the activity LED |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Checkpoint comparison failed on the last sequence |
| samp1 | output | 8 | First masked status checkpoint |
| samp2 | output | 8 | Second masked status checkpoint |
| samp3 | output | 8 | Third masked status checkpoint |

## Verification
The hazardous overlap is a start request arriving in the same cycle as the last write window closes, when completion, the mismatch verdict and the return to idle all happen on one edge. The bench raises `go` exactly in the final busy cycle of a detach. It then checks that done pulses, that busy does not rise again afterwards, and that the data lines still hold the detach's final byte. A second overlap is a request pulsed in the middle of a run. It is judged by the unchanged run length, data trace and third sample of the running sequence.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

    localparam int PAT_LEN    = 13;
    localparam int CFG_REGS   = 4;
    localparam int ATTACH_LEN = 2 * PAT_LEN + 3 + 4 * CFG_REGS;
    localparam int DETACH_LEN = PAT_LEN + 1;
    localparam int IDX_W      = $clog2(ATTACH_LEN);

    localparam logic       OP_DETACH    = 1'b1;
    localparam logic [7:0] SEL_INIT     = 8'h00;
    localparam logic [7:0] SEL_ATTACH   = 8'hE0;
    localparam logic [7:0] SEL_DETACH   = 8'h30;
    localparam logic [7:0] MASK_WIDE    = 8'hB8;
    localparam logic [7:0] MASK_NARROW  = 8'h38;
    localparam logic [7:0] WANT_S1      = 8'hB8;
    localparam logic [7:0] WANT_S2      = 8'h18;
    localparam logic [7:0] WANT_S3_ATT  = 8'h30;
    localparam logic [7:0] WANT_S3_DET  = 8'h38;
    localparam logic [7:0] ALT_CTRL_FLIP = 8'h8B;
    localparam logic [7:0] LED_OFF_CTRL = 8'h8C;
    localparam logic [7:0] REG_SEL_BASE = 8'h60;

    typedef enum logic [1:0] {TAP_NONE, TAP_S1, TAP_S2, TAP_S3} tap_e;

    typedef struct packed {
        logic       to_ctrl;
        logic [7:0] val;
        tap_e       tap;
    } step_t;

    function automatic step_t mk_step(input logic c, input logic [7:0] v, input tap_e t);
        step_t s;
        s.to_ctrl = c;
        s.val     = v;
        s.tap     = t;
        return s;
    endfunction

    // One handshake pass; k counts from 0 to PAT_LEN-1
    function automatic step_t pat_step(input logic [IDX_W-1:0] k, input logic [7:0] sel);
        case (k)
            6'd0:    return mk_step(1'b1, 8'h04, TAP_NONE);
            6'd1:    return mk_step(1'b0, 8'h22, TAP_NONE);
            6'd2:    return mk_step(1'b0, 8'hAA, TAP_NONE);
            6'd3:    return mk_step(1'b0, 8'h55, TAP_NONE);
            6'd4:    return mk_step(1'b0, 8'h00, TAP_NONE);
            6'd5:    return mk_step(1'b0, 8'hFF, TAP_S1);
            6'd6:    return mk_step(1'b0, 8'h87, TAP_S2);
            6'd7:    return mk_step(1'b0, 8'h78, TAP_S3);
            6'd8:    return mk_step(1'b0, sel,   TAP_NONE);
            6'd9:    return mk_step(1'b1, 8'h04, TAP_NONE);
            6'd10:   return mk_step(1'b1, 8'h05, TAP_NONE);
            6'd11:   return mk_step(1'b1, 8'h04, TAP_NONE);
            default: return mk_step(1'b0, 8'hFF, TAP_NONE);
        endcase
    endfunction

    function automatic logic [7:0] cfg_addr(input logic [IDX_W-1:0] k);
        case (k)
            6'd0:    return 8'h08;
            6'd1:    return 8'h0C;
            6'd2:    return 8'h0A;
            default: return 8'h12;
        endcase
    endfunction

    function automatic logic [7:0] cfg_val(input logic [IDX_W-1:0] k);
        case (k)
            6'd0:    return 8'h10;
            6'd1:    return 8'h14;
            6'd2:    return 8'h38;
            default: return 8'h10;
        endcase
    endfunction

    function automatic step_t step_at(input logic op, input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] j;
        logic [IDX_W-1:0] k;
        if (op == OP_DETACH) begin
            if (idx < IDX_W'(PAT_LEN)) return pat_step(idx, SEL_DETACH);
            return mk_step(1'b1, LED_OFF_CTRL, TAP_NONE);
        end
        if (idx < IDX_W'(PAT_LEN))     return pat_step(idx, SEL_INIT);
        if (idx < IDX_W'(2 * PAT_LEN)) return pat_step(idx - IDX_W'(PAT_LEN), SEL_ATTACH);
        if (idx == IDX_W'(2 * PAT_LEN))     return mk_step(1'b0, 8'h00, TAP_NONE);
        if (idx == IDX_W'(2 * PAT_LEN + 1)) return mk_step(1'b1, 8'h01, TAP_NONE);
        if (idx == IDX_W'(2 * PAT_LEN + 2)) return mk_step(1'b1, 8'h04, TAP_NONE);
        j = idx - IDX_W'(2 * PAT_LEN + 3);
        k = j / IDX_W'(4);
        case (j % IDX_W'(4))
            6'd0:    return mk_step(1'b0, REG_SEL_BASE + cfg_addr(k), TAP_NONE);
            6'd1:    return mk_step(1'b1, 8'h01, TAP_NONE);
            6'd2:    return mk_step(1'b0, cfg_val(k), TAP_NONE);
            default: return mk_step(1'b1, 8'h04, TAP_NONE);
        endcase
    endfunction

    function automatic logic [7:0] tap_mask(input tap_e t);
        return (t == TAP_S3) ? MASK_NARROW : MASK_WIDE;
    endfunction

    function automatic logic [7:0] map_status(input logic alt, input logic [4:0] ln);
        if (alt) return {~ln[1], ln[0], ln[2], ln[3], ln[4], 3'b000};
        return {ln, 3'b000};
    endfunction

endpackage

// File: rtl/pp_step_rom.sv
module pp_step_rom
    import pp_seq_pkg::*;
(
    input  logic             op,
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);
    always_comb begin
        step = step_at(op, idx);
        if (op == OP_DETACH) last = (idx == IDX_W'(DETACH_LEN - 1));
        else                 last = (idx == IDX_W'(ATTACH_LEN - 1));
    end
endmodule

// File: rtl/pp_hold_timer.sv
module pp_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HOLD_W-1:0] hold,
    output logic              apply,
    output logic              win_end
);
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_eff;

    always_comb begin
        hold_eff = (hold == '0) ? HOLD_W'(1) : hold;
        apply    = run && (cnt_q == '0);
        win_end  = run && (cnt_q >= hold_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || win_end) cnt_q <= '0;
        else                        cnt_q <= cnt_q + HOLD_W'(1);
    end
endmodule

// File: rtl/pp_status_map.sv
module pp_status_map
    import pp_seq_pkg::*;
(
    input  logic       alt,
    input  logic [4:0] lines,
    output logic [7:0] std_byte
);
    always_comb std_byte = map_status(alt, lines);
endmodule

// File: rtl/pp_attach_seq.sv
module pp_attach_seq
    import pp_seq_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              op,
    input  logic              alt_mode,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [4:0]        pp_status,
    output logic [7:0]        pp_data,
    output logic [7:0]        pp_ctrl,
    output logic              busy,
    output logic              done,
    output logic              mismatch,
    output logic [7:0]        samp1,
    output logic [7:0]        samp2,
    output logic [7:0]        samp3
);
    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e              st_q;
    logic             op_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       data_q, ctrl_q, s1_q, s2_q, s3_q;
    logic             done_q, mis_q;

    step_t            cur;
    logic             cur_last, apply, win_end, running;
    logic [7:0]       std_stat, tapped, want_s3;

    assign running = (st_q == ST_RUN);

    pp_step_rom u_rom (
        .op   (op_q),
        .idx  (idx_q),
        .step (cur),
        .last (cur_last)
    );

    pp_hold_timer #(.HOLD_W(HOLD_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .hold    (hold_cycles),
        .apply   (apply),
        .win_end (win_end)
    );

    pp_status_map u_map (
        .alt      (alt_mode),
        .lines    (pp_status),
        .std_byte (std_stat)
    );

    always_comb begin
        tapped  = std_stat & tap_mask(cur.tap);
        want_s3 = (op_q == OP_DETACH) ? WANT_S3_DET : WANT_S3_ATT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= 1'b0;
            idx_q  <= '0;
            data_q <= 8'h00;
            ctrl_q <= 8'h00;
            s1_q   <= 8'h00;
            s2_q   <= 8'h00;
            s3_q   <= 8'h00;
            done_q <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        st_q  <= ST_RUN;
                        op_q  <= op;
                        idx_q <= '0;
                        mis_q <= 1'b0;
                    end
                end
                default: begin
                    if (apply) begin
                        if (cur.to_ctrl) ctrl_q <= cur.val;
                        else             data_q <= cur.val;
                    end
                    if (win_end) begin
                        case (cur.tap)
                            TAP_S1:  s1_q <= tapped;
                            TAP_S2:  s2_q <= tapped;
                            TAP_S3:  s3_q <= tapped;
                            default: ;
                        endcase
                        if (cur_last) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                            mis_q  <= (s1_q != WANT_S1) || (s2_q != WANT_S2) ||
                                      (s3_q != want_s3);
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign pp_data  = data_q;
    assign pp_ctrl  = ctrl_q ^ (alt_mode ? ALT_CTRL_FLIP : 8'h00);
    assign busy     = running;
    assign done     = done_q;
    assign mismatch = mis_q;
    assign samp1    = s1_q;
    assign samp2    = s2_q;
    assign samp3    = s3_q;
endmodule

// File: rtl/pp_attach_seq_chk.sv
module pp_attach_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       mismatch,
    input logic [7:0] pp_data,
    input logic [7:0] samp1,
    input logic [7:0] samp2,
    input logic [7:0] samp3
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_mismatch_at_end_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(mismatch) |-> done);

    p_samples_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(samp1) && $stable(samp2) && $stable(samp3)));

    p_idle_data_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go) |=> $stable(pp_data));
endmodule

bind pp_attach_seq pp_attach_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .busy     (busy),
    .done     (done),
    .mismatch (mismatch),
    .pp_data  (pp_data),
    .samp1    (samp1),
    .samp2    (samp2),
    .samp3    (samp3)
);

// File: tb/tb_pp_attach_seq.sv
module tb_pp_attach_seq;
    localparam int HOLD_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              go = 1'b0;
    logic              op = 1'b0;
    logic              alt_mode = 1'b0;
    logic [HOLD_W-1:0] hold_cycles = 8'd1;
    logic [4:0]        pp_status;
    logic [7:0]        pp_data, pp_ctrl, samp1, samp2, samp3;
    logic              busy, done, mismatch;

    always #2 clk = ~clk;

    pp_attach_seq #(.HOLD_W(HOLD_W)) dut (
        .clk, .rst, .go, .op, .alt_mode, .hold_cycles, .pp_status,
        .pp_data, .pp_ctrl, .busy, .done, .mismatch, .samp1, .samp2, .samp3
    );

    // Device model: chosen standard status byte per marker, encoded to raw lines (R6)
    logic [7:0] r_ff = 8'h00, r_87 = 8'h00, r_78 = 8'h00;
    logic [7:0] dev_std;
    always_comb begin
        case (pp_data)
            8'hFF:   dev_std = r_ff;
            8'h87:   dev_std = r_87;
            8'h78:   dev_std = r_78;
            default: dev_std = 8'h00;
        endcase
        if (alt_mode) pp_status = {dev_std[3], dev_std[4], dev_std[5], ~dev_std[7], dev_std[6]};
        else          pp_status = dev_std[7:3];
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    // Expected data trace (R2, R3, R4), consecutive repeats collapsed
    logic [7:0] exp_tr [64];
    int         n_exp;
    logic [7:0] obs_tr [64];
    int         n_obs;
    logic [7:0] prev_d;

    function automatic void push_exp(input logic [7:0] v);
        logic [7:0] last;
        last = (n_exp == 0) ? prev_d : exp_tr[n_exp-1];
        if (v != last && n_exp < 64) begin
            exp_tr[n_exp] = v;
            n_exp++;
        end
    endfunction

    function automatic void push_pat(input logic [7:0] sel);
        push_exp(8'h22); push_exp(8'hAA); push_exp(8'h55); push_exp(8'h00);
        push_exp(8'hFF); push_exp(8'h87); push_exp(8'h78); push_exp(sel);
        push_exp(8'hFF);
    endfunction

    function automatic void build_exp(input logic dop);
        n_exp = 0;
        if (dop) begin
            push_pat(8'h30);
        end else begin
            push_pat(8'h00);
            push_pat(8'hE0);
            push_exp(8'h00);
            push_exp(8'h68); push_exp(8'h10);
            push_exp(8'h6C); push_exp(8'h14);
            push_exp(8'h6A); push_exp(8'h38);
            push_exp(8'h72); push_exp(8'h10);
        end
    endfunction

    // Runs one sequence; inject > 0 pulses go (other op) at that busy cycle
    task automatic run_seq(input logic dop, input logic dalt, input logic [7:0] dhold,
                           input logic [7:0] rf, input logic [7:0] r8, input logic [7:0] r7,
                           input logic exp_mis, input int inject);
        int busy_n;
        int heff;
        int n_steps;
        logic [7:0] m3;
        logic [7:0] led;
        heff    = (dhold == 0) ? 1 : int'(dhold);
        n_steps = dop ? 14 : 45;
        @(negedge clk);
        op = dop; alt_mode = dalt; hold_cycles = dhold;
        r_ff = rf; r_87 = r8; r_78 = r7;
        prev_d = pp_data;
        build_exp(dop);
        n_obs = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        busy_n = 0;
        while (busy && busy_n < 5000) begin
            busy_n++;
            if (pp_data != ((n_obs == 0) ? prev_d : obs_tr[n_obs-1]) && n_obs < 64) begin
                obs_tr[n_obs] = pp_data;
                n_obs++;
            end
            if (inject != 0 && busy_n == inject) begin
                go = 1'b1; op = ~dop;
            end else begin
                go = 1'b0; op = dop;
            end
            @(negedge clk);
        end
        go = 1'b0;
        chk(busy_n == n_steps * (heff + 1), "R8", "busy length", busy_n, n_steps * (heff + 1));
        chk(done == 1'b1, "R9", "done at end", done, 1);
        chk(n_obs == n_exp, dop ? "R4" : "R3", "data trace length", n_obs, n_exp);
        for (int i = 0; i < n_exp && i < n_obs; i++)
            chk(obs_tr[i] == exp_tr[i], "R2", $sformatf("data step %0d", i), obs_tr[i], exp_tr[i]);
        m3 = r7 & 8'h38;
        chk(samp1 == (rf & 8'hB8), "R5", "samp1", samp1, rf & 8'hB8);
        chk(samp2 == (r8 & 8'hB8), "R5", "samp2", samp2, r8 & 8'hB8);
        chk(samp3 == m3, "R6", "samp3", samp3, m3);
        chk(mismatch == exp_mis, "R10", "mismatch", mismatch, exp_mis);
        led = dop ? 8'h8C : 8'h04;
        if (dalt) led = led ^ 8'h8B;
        chk(pp_ctrl == led, "R7", "final ctrl pins", pp_ctrl, led);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
        chk(busy == 1'b0, "R11", "no restart", busy, 0);
    endtask

    typedef struct packed {
        logic       op;
        logic       alt;
        logic [7:0] hold;
        logic [7:0] rff;
        logic [7:0] r87;
        logic [7:0] r78;
        logic       mis;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd2, 8'hFF, 8'h1F, 8'h37, 1'b0},
        '{1'b1, 1'b0, 8'd1, 8'hB8, 8'h18, 8'h38, 1'b0},
        '{1'b0, 1'b1, 8'd0, 8'hB8, 8'h18, 8'h30, 1'b0},
        '{1'b1, 1'b1, 8'd3, 8'hFF, 8'h5C, 8'h3F, 1'b0},
        '{1'b0, 1'b0, 8'd1, 8'hB8, 8'h18, 8'h38, 1'b1},
        '{1'b1, 1'b1, 8'd2, 8'h00, 8'h18, 8'h38, 1'b1},
        '{1'b0, 1'b1, 8'd4, 8'hB8, 8'h98, 8'h30, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && mismatch == 0, "R1", "flags after reset",
            {busy, done, mismatch}, 0);
        chk(pp_data == 8'h00 && pp_ctrl == 8'h00, "R1", "port after reset",
            {pp_data, pp_ctrl}, 0);
        chk(samp1 == 0 && samp2 == 0 && samp3 == 0, "R1", "samples after reset",
            {samp1, samp2, samp3}, 0);

        for (int v = 0; v < NV; v++)
            run_seq(VECS[v].op, VECS[v].alt, VECS[v].hold, VECS[v].rff, VECS[v].r87,
                    VECS[v].r78, VECS[v].mis, 0);

        // R11: go pulsed mid-run with the other op has no effect
        run_seq(1'b1, 1'b0, 8'd1, 8'hB8, 8'h18, 8'h38, 1'b0, 5);

        // R10: a new good run clears an old mismatch
        run_seq(1'b1, 1'b0, 8'd1, 8'hB8, 8'h18, 8'h30, 1'b1, 0);
        run_seq(1'b1, 1'b0, 8'd1, 8'hB8, 8'h18, 8'h38, 1'b0, 0);

        // R11: go in the final busy cycle of a detach (28 busy cycles at hold 1)
        @(negedge clk);
        op = 1'b1; alt_mode = 1'b0; hold_cycles = 8'd1;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (27) @(negedge clk);
        chk(busy == 1'b1, "R11", "still busy in last cycle", busy, 1);
        go = 1'b1; op = 1'b0;
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R11", "completion beside go",
            {done, busy}, 2'b10);
        go = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R11", "late go ignored", busy, 0);
        chk(pp_data == 8'hFF, "R11", "data unchanged", pp_data, 8'hFF);

        // R12: reset in mid-sequence
        @(negedge clk);
        op = 1'b0; alt_mode = 1'b1; hold_cycles = 8'd1;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 0 && done == 0 && mismatch == 0, "R12", "flags after mid reset",
            {busy, done, mismatch}, 0);
        chk(pp_data == 8'h00, "R12", "data after mid reset", pp_data, 0);
        chk(pp_ctrl == 8'h8B, "R12", "alt ctrl after mid reset", pp_ctrl, 8'h8B);
        chk(samp1 == 0 && samp2 == 0 && samp3 == 0, "R12", "samples after mid reset",
            {samp1, samp2, samp3}, 0);

        finish_run();
    end
endmodule